// File: doc/BRIEF.md
# Machine Status and Trap Control Register Legalizer

This block holds the machine and supervisor control registers that a hart uses for status, interrupt enables, interrupt and exception delegation, the extension set, and trap vectors. Every software write is legalized on the way in. Each register keeps only the bits it implements. Privilege fields are forced to modes that exist. Coupled extension bits stay consistent. The dirty-summary bit and the width fields are computed on the fly rather than stored.

The supervisor views of status, interrupt-pending and interrupt-enable are masked aliases of the machine copies. They have no storage of their own. A read returns the addressed register one clock later. A read of an address the block does not own raises a one-cycle illegal flag. The extension set that the hart can support arrives on `max_isa_i`, and the register width is the `XLEN` parameter (32 or 64; the bench uses 64).

Top module: `csr_wlrl_unit`

## Requirements
- R1: A write to mip (0x344) changes only bits 1 and 5. The other mip bits read 0. mip changes on no other write except sip (0x144).
- R2: mie (0x304) stores only bits 1, 3, 5, 7, 9 and 12. mideleg (0x303) stores only bits 1, 5, 9 and 12. All other bits read 0.
- R3: medeleg (0x302) stores only bits 0, 3, 8, 12, 13 and 15.
- R4: The MPP field of mstatus (0x300) is bits 12:11 and resets to 3. On a write the value is legalized in this order:
  - With the U bit (bit 20) of `max_isa_i` clear, MPP becomes 3.
  - Otherwise a written 2, or any write with the S bit (bit 18) clear, gives 0.
  - Otherwise the written value is kept.
- R5: The writable mstatus bits are 1, 3, 5, 7, 13, 14 and 17 to 22, plus bit 8 when S is present. Bit XLEN-1 of mstatus reads 1 exactly when bits 14:13 or bits 16:15 are both 1; bits 16:15 always read 0. For XLEN 64, bits 33:32 and 35:34 read 2.
- R6: misa (0x301) has its top two bits set to 1 for XLEN 32 and 2 for XLEN 64. Its bits 25:0 read as the stored value ANDed with `max_isa_i`. Only bits 0, 2, 3, 5 and 12 that are also set in `max_isa_i` take a write. A written bit 5 of 0 forces written bit 3 to 0.
- R7: mtvec (0x305) stores the written value with bit 1 cleared. stvec (0x105) stores it with bits 1:0 cleared.
- R8: A write to sstatus (0x100) updates only those mstatus bits among 1, 5, 8, 13 to 16, 18 and 19 that R5 makes writable. A read of sstatus returns mstatus masked to those bits, plus bits 33:32 (XLEN 64) and bit XLEN-1.
- R9: A read of sip (0x144) returns mip AND mideleg. A read of sie (0x104) returns mie AND mideleg. A write to sip changes only the mip bits of R1 that are set in mideleg. A write to sie changes only the mie bits of R2 that are set in mideleg.
- R10: A read of any other address drives `illegal_o` high for the one cycle after the read, with `rdata_o` 0. A write to such an address changes nothing.
- R11: `rdata_o` shows the addressed register one cycle after `rd_en_i`, with the value from before a write in the same cycle. It holds while `rd_en_i` is low.
- R12: After reset the outputs are as follows:
  - mstatus holds only MPP=3 and the width fields of R5.
  - misa is the width code over `max_isa_i`.
  - All other registers, `rdata_o` and `illegal_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 12 | Register address |
| wdata_i | input | XLEN | Write data |
| max_isa_i | input | 26 | Extension letters the hart may enable, bit n is letter A+n |
| rdata_o | output | XLEN | Registered read data |
| illegal_o | output | 1 | One-cycle flag for a read of an unowned address |
| mstatus_o | output | XLEN | Legalized machine status |
| misa_o | output | XLEN | Current extension set with width code |
| medeleg_o | output | XLEN | Exception delegation |
| mideleg_o | output | XLEN | Interrupt delegation |
| mie_o | output | XLEN | Interrupt enables |
| mip_o | output | XLEN | Software-writable interrupt pending bits |
| mtvec_o | output | XLEN | Machine trap vector |
| stvec_o | output | XLEN | Supervisor trap vector |

## Verification
The bench first writes all ones and then all zeros to each register. This separates the per-register masks from any shared mask.

MPP sweeps each value under three extension sets: full, no supervisor, and no user. This tells the H remap apart from the missing-mode remaps. The extension register is written with F and D in every combination, which separates the coupling from the plain mask.

The supervisor aliases are exercised with mideleg both empty and partly set, so leakage through the alias is visible. A long random mix of reads and writes over owned and unowned addresses, with the extension set changing under it, catches read-during-write ordering and stray updates.

// File: rtl/csr_legal_pkg.sv
package csr_legal_pkg;
  localparam logic [11:0] A_SSTATUS = 12'h100;
  localparam logic [11:0] A_SIE     = 12'h104;
  localparam logic [11:0] A_STVEC   = 12'h105;
  localparam logic [11:0] A_SIP     = 12'h144;
  localparam logic [11:0] A_MSTATUS = 12'h300;
  localparam logic [11:0] A_MISA    = 12'h301;
  localparam logic [11:0] A_MEDELEG = 12'h302;
  localparam logic [11:0] A_MIDELEG = 12'h303;
  localparam logic [11:0] A_MIE     = 12'h304;
  localparam logic [11:0] A_MTVEC   = 12'h305;
  localparam logic [11:0] A_MIP     = 12'h344;

  localparam logic [31:0] MIP_WMASK   = 32'h0000_0022;
  localparam logic [31:0] MIE_WMASK   = 32'h0000_12AA;
  localparam logic [31:0] MIDEL_WMASK = 32'h0000_1222;
  localparam logic [31:0] MEDEL_WMASK = 32'h0000_B109;
  localparam logic [31:0] MST_WMASK   = 32'h007E_60AA;
  localparam logic [31:0] MST_SPP     = 32'h0000_0100;
  localparam logic [31:0] SST_MASK    = 32'h000D_E122;
  localparam logic [25:0] MISA_WMASK  = 26'h000_102D;

  localparam int ISA_D = 3;
  localparam int ISA_F = 5;
  localparam int ISA_S = 18;
  localparam int ISA_U = 20;

  typedef struct packed {
    logic mstatus, sstatus, misa, medeleg, mideleg, mie, sie, mip, sip, mtvec, stvec;
  } csr_sel_t;

  function automatic logic [1:0] xlen_code(input int xl);
    return (xl == 32) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/csr_status_regs.sv
module csr_status_regs import csr_legal_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_m_i,
  input  logic            wr_s_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            u_ok_i,
  input  logic            s_ok_i,
  output logic [XLEN-1:0] mstatus_o,
  output logic [XLEN-1:0] sstatus_o
);
  localparam int SW = 23;

  logic [SW-1:0]   st_q;
  logic [1:0]      mpp_q;
  logic [SW-1:0]   m_wmask, s_wmask;
  logic [XLEN-1:0] xl_bits, uxl_mask, base;
  logic            sd;

  assign m_wmask = MST_WMASK[SW-1:0] | (s_ok_i ? MST_SPP[SW-1:0] : '0);
  assign s_wmask = SST_MASK[SW-1:0] & m_wmask;

  function automatic logic [1:0] legal_mpp(input logic [1:0] v, input logic u, input logic s);
    if (!u)                   return 2'b11;
    else if (v == 2'b10 || !s) return 2'b00;
    else                      return v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      mpp_q <= 2'b11;
    end else if (wr_m_i) begin
      st_q  <= (st_q & ~m_wmask) | (wdata_i[SW-1:0] & m_wmask);
      mpp_q <= legal_mpp(wdata_i[12:11], u_ok_i, s_ok_i);
    end else if (wr_s_i) begin
      st_q  <= (st_q & ~s_wmask) | (wdata_i[SW-1:0] & s_wmask);
    end
  end

  generate
    if (XLEN == 64) begin : g_xl64
      localparam logic [1:0] XC = xlen_code(XLEN);
      assign xl_bits  = XLEN'({28'd0, XC, XC, 32'd0});
      assign uxl_mask = XLEN'(64'h0000_0003_0000_0000);
    end else begin : g_xl32
      assign xl_bits  = '0;
      assign uxl_mask = '0;
    end
  endgenerate

  assign sd = (&st_q[14:13]) | (&st_q[16:15]);

  always_comb begin
    base            = '0;
    base[SW-1:0]    = st_q;
    base[12:11]     = mpp_q;
    base[XLEN-1]    = sd;
  end

  assign mstatus_o = base | xl_bits;
  assign sstatus_o = mstatus_o & (XLEN'(SST_MASK) | uxl_mask | (XLEN'(1) << (XLEN-1)));

  AST_MPP_NO_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_m_i && !u_ok_i) |=> (mstatus_o[12:11] == 2'b11)); // R4
  AST_MPP_NEVER_H: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mstatus_o[12:11] != 2'b10); // R4
  AST_SD_ON_FS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_m_i && wdata_i[14:13] == 2'b11) |=> mstatus_o[XLEN-1]); // R5
  AST_SST_KEEPS_MIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_s_i && !wr_m_i) |=> $stable(mstatus_o[3])); // R8
endmodule

// File: rtl/csr_irq_regs.sv
module csr_irq_regs import csr_legal_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_mip_i,
  input  logic            wr_sip_i,
  input  logic            wr_mie_i,
  input  logic            wr_sie_i,
  input  logic            wr_mideleg_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] mip_o,
  output logic [XLEN-1:0] mie_o,
  output logic [XLEN-1:0] mideleg_o,
  output logic [XLEN-1:0] sip_o,
  output logic [XLEN-1:0] sie_o
);
  localparam int IW = 13;

  logic [IW-1:0] mip_q, mie_q, mid_q;
  logic [IW-1:0] w, mip_m, mie_m;

  assign w = wdata_i[IW-1:0];

  always_comb begin
    mip_m = '0;
    mie_m = '0;
    if (wr_mip_i) mip_m = MIP_WMASK[IW-1:0];
    if (wr_sip_i) mip_m = MIP_WMASK[IW-1:0] & mid_q;
    if (wr_mie_i) mie_m = MIE_WMASK[IW-1:0];
    if (wr_sie_i) mie_m = MIE_WMASK[IW-1:0] & mid_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mip_q <= '0;
      mie_q <= '0;
      mid_q <= '0;
    end else begin
      mip_q <= (mip_q & ~mip_m) | (w & mip_m);
      mie_q <= (mie_q & ~mie_m) | (w & mie_m);
      if (wr_mideleg_i) mid_q <= w & MIDEL_WMASK[IW-1:0];
    end
  end

  assign mip_o     = XLEN'(mip_q);
  assign mie_o     = XLEN'(mie_q);
  assign mideleg_o = XLEN'(mid_q);
  assign sip_o     = XLEN'(mip_q & mid_q);
  assign sie_o     = XLEN'(mie_q & mid_q);

  AST_MIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_mip_i || wr_sip_i) |=> $stable(mip_o)); // R1
  AST_MIDELEG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mideleg_o & ~XLEN'(MIDEL_WMASK)) == '0); // R2
  AST_SIE_SCOPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sie_i |=> ((mie_o ^ $past(mie_o)) & ~$past(mideleg_o)) == '0); // R9
endmodule

// File: rtl/csr_trap_regs.sv
module csr_trap_regs import csr_legal_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_medeleg_i,
  input  logic            wr_misa_i,
  input  logic            wr_mtvec_i,
  input  logic            wr_stvec_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [25:0]     max_isa_i,
  output logic [XLEN-1:0] medeleg_o,
  output logic [XLEN-1:0] misa_o,
  output logic [XLEN-1:0] mtvec_o,
  output logic [XLEN-1:0] stvec_o
);
  localparam int DW = 16;

  logic [DW-1:0]   med_q;
  logic [25:0]     ext_q, ext_w, ext_m;
  logic [XLEN-1:0] mtvec_q, stvec_q;

  // dropping F also drops D in the same write
  always_comb begin
    ext_w = wdata_i[25:0];
    if (!ext_w[ISA_F]) ext_w[ISA_D] = 1'b0;
    ext_m = MISA_WMASK & max_isa_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      med_q   <= '0;
      ext_q   <= '1;
      mtvec_q <= '0;
      stvec_q <= '0;
    end else begin
      if (wr_medeleg_i) med_q   <= wdata_i[DW-1:0] & MEDEL_WMASK[DW-1:0];
      if (wr_misa_i)    ext_q   <= (ext_q & ~ext_m) | (ext_w & ext_m);
      if (wr_mtvec_i)   mtvec_q <= {wdata_i[XLEN-1:2], 1'b0, wdata_i[0]};
      if (wr_stvec_i)   stvec_q <= {wdata_i[XLEN-1:2], 2'b00};
    end
  end

  assign medeleg_o = XLEN'(med_q);
  assign misa_o    = (XLEN'(xlen_code(XLEN)) << (XLEN-2)) | XLEN'(ext_q & max_isa_i);
  assign mtvec_o   = mtvec_q;
  assign stvec_o   = stvec_q;

  AST_MEDELEG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (medeleg_o & ~XLEN'(MEDEL_WMASK)) == '0); // R3
  AST_MISA_D_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_misa_i && !wdata_i[ISA_F]) |=> !misa_o[ISA_D]); // R6
  AST_TVEC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mtvec_o[1] && (stvec_o[1:0] == 2'b00)); // R7
endmodule

// File: rtl/csr_wlrl_unit.sv
module csr_wlrl_unit import csr_legal_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [11:0]     addr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [25:0]     max_isa_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] mstatus_o,
  output logic [XLEN-1:0] misa_o,
  output logic [XLEN-1:0] medeleg_o,
  output logic [XLEN-1:0] mideleg_o,
  output logic [XLEN-1:0] mie_o,
  output logic [XLEN-1:0] mip_o,
  output logic [XLEN-1:0] mtvec_o,
  output logic [XLEN-1:0] stvec_o
);
  csr_sel_t        sel, wr;
  logic            known;
  logic [XLEN-1:0] sstatus, sip, sie, rd_val;
  logic [XLEN-1:0] rdata_q;
  logic            ill_q;

  always_comb begin
    sel = '0;
    unique case (addr_i)
      A_MSTATUS: sel.mstatus = 1'b1;
      A_SSTATUS: sel.sstatus = 1'b1;
      A_MISA:    sel.misa    = 1'b1;
      A_MEDELEG: sel.medeleg = 1'b1;
      A_MIDELEG: sel.mideleg = 1'b1;
      A_MIE:     sel.mie     = 1'b1;
      A_SIE:     sel.sie     = 1'b1;
      A_MIP:     sel.mip     = 1'b1;
      A_SIP:     sel.sip     = 1'b1;
      A_MTVEC:   sel.mtvec   = 1'b1;
      A_STVEC:   sel.stvec   = 1'b1;
      default:   sel         = '0;
    endcase
  end

  assign known = |sel;
  assign wr    = wr_en_i ? sel : '0;

  csr_status_regs #(.XLEN(XLEN)) u_status (
    .clk_i, .rst_ni,
    .wr_m_i(wr.mstatus), .wr_s_i(wr.sstatus), .wdata_i,
    .u_ok_i(max_isa_i[ISA_U]), .s_ok_i(max_isa_i[ISA_S]),
    .mstatus_o, .sstatus_o(sstatus)
  );

  csr_irq_regs #(.XLEN(XLEN)) u_irq (
    .clk_i, .rst_ni,
    .wr_mip_i(wr.mip), .wr_sip_i(wr.sip), .wr_mie_i(wr.mie), .wr_sie_i(wr.sie),
    .wr_mideleg_i(wr.mideleg), .wdata_i,
    .mip_o, .mie_o, .mideleg_o, .sip_o(sip), .sie_o(sie)
  );

  csr_trap_regs #(.XLEN(XLEN)) u_trap (
    .clk_i, .rst_ni,
    .wr_medeleg_i(wr.medeleg), .wr_misa_i(wr.misa),
    .wr_mtvec_i(wr.mtvec), .wr_stvec_i(wr.stvec),
    .wdata_i, .max_isa_i,
    .medeleg_o, .misa_o, .mtvec_o, .stvec_o
  );

  always_comb begin
    rd_val = '0;
    if (sel.mstatus) rd_val = mstatus_o;
    if (sel.sstatus) rd_val = sstatus;
    if (sel.misa)    rd_val = misa_o;
    if (sel.medeleg) rd_val = medeleg_o;
    if (sel.mideleg) rd_val = mideleg_o;
    if (sel.mie)     rd_val = mie_o;
    if (sel.sie)     rd_val = sie;
    if (sel.mip)     rd_val = mip_o;
    if (sel.sip)     rd_val = sip;
    if (sel.mtvec)   rd_val = mtvec_o;
    if (sel.stvec)   rd_val = stvec_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      ill_q   <= 1'b0;
    end else begin
      ill_q <= rd_en_i & ~known;
      if (rd_en_i) rdata_q <= rd_val;
    end
  end

  assign rdata_o   = rdata_q;
  assign illegal_o = ill_q;

  AST_ILL_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(rd_en_i)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R11
endmodule

// File: tb/tb_csr_wlrl_unit.sv
`timescale 1ns/1ps
module tb_csr_wlrl_unit;
  localparam int XLEN = 64;
  localparam logic [25:0] ISA_FULL = 26'h14112D;
  localparam logic [25:0] ISA_NO_S = 26'h10112D;
  localparam logic [25:0] ISA_NO_U = 26'h00112D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [25:0] max_isa = ISA_FULL;
  logic [63:0] rdata, mstatus, misa, medeleg, mideleg, mie, mip, mtvec, stvec;
  logic illegal;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  csr_wlrl_unit #(.XLEN(XLEN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .max_isa_i(max_isa), .rdata_o(rdata), .illegal_o(illegal),
    .mstatus_o(mstatus), .misa_o(misa), .medeleg_o(medeleg), .mideleg_o(mideleg),
    .mie_o(mie), .mip_o(mip), .mtvec_o(mtvec), .stvec_o(stvec)
  );

  // reference state
  logic [63:0] r_st, r_mip, r_mie, r_mid, r_med, r_mtvec, r_stvec, r_rdata;
  logic [25:0] r_ext;
  logic [1:0]  r_mpp;
  logic        r_ill;

  function automatic logic [63:0] m_mstatus();
    logic [63:0] v;
    v = r_st | (64'(r_mpp) << 11) | (64'd2 << 32) | (64'd2 << 34);
    if (r_st[14:13] == 2'b11 || r_st[16:15] == 2'b11) v[63] = 1'b1;
    return v;
  endfunction

  function automatic logic [63:0] m_misa();
    return (64'd2 << 62) | 64'(r_ext & max_isa);
  endfunction

  function automatic bit m_known(input logic [11:0] a);
    return a inside {12'h100, 12'h104, 12'h105, 12'h144, 12'h300, 12'h301,
                     12'h302, 12'h303, 12'h304, 12'h305, 12'h344};
  endfunction

  function automatic logic [63:0] m_read(input logic [11:0] a);
    case (a)
      12'h300: return m_mstatus();
      12'h100: return m_mstatus() & (64'h000D_E122 | (64'd3 << 32) | (64'd1 << 63));
      12'h301: return m_misa();
      12'h302: return r_med;
      12'h303: return r_mid;
      12'h304: return r_mie;
      12'h104: return r_mie & r_mid;
      12'h344: return r_mip;
      12'h144: return r_mip & r_mid;
      12'h305: return r_mtvec;
      12'h105: return r_stvec;
      default: return 64'd0;
    endcase
  endfunction

  task automatic m_step(input bit w, input bit r, input logic [11:0] a, input logic [63:0] d);
    logic [63:0] msk;
    logic [25:0] e;
    if (r) begin
      r_rdata = m_read(a);
      r_ill   = !m_known(a);
    end else r_ill = 1'b0;
    if (w) begin
      msk = 64'h007E_60AA | (max_isa[18] ? 64'h100 : 64'h0);
      case (a)
        12'h300: begin
          r_st = (r_st & ~msk) | (d & msk);
          if (!max_isa[20]) r_mpp = 2'd3;
          else if (d[12:11] == 2'd2 || !max_isa[18]) r_mpp = 2'd0;
          else r_mpp = d[12:11];
        end
        12'h100: begin
          msk = msk & 64'h000D_E122;
          r_st = (r_st & ~msk) | (d & msk);
        end
        12'h301: begin
          e = d[25:0];
          if (!e[5]) e[3] = 1'b0;
          r_ext = (r_ext & ~(26'h102D & max_isa)) | (e & 26'h102D & max_isa);
        end
        12'h302: r_med = d & 64'hB109;
        12'h303: r_mid = d & 64'h1222;
        12'h304: r_mie = d & 64'h12AA;
        12'h104: begin msk = 64'h12AA & r_mid; r_mie = (r_mie & ~msk) | (d & msk); end
        12'h344: r_mip = d & 64'h22;
        12'h144: begin msk = 64'h22 & r_mid; r_mip = (r_mip & ~msk) | (d & msk); end
        12'h305: r_mtvec = d & ~64'h2;
        12'h105: r_stvec = d & ~64'h3;
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string tag, input string ctx, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, ctx, act, exp);
    end
  endtask

  task automatic compare_all(input string ctx);
    chk("R4 R5 R8 mstatus", ctx, mstatus, m_mstatus());
    chk("R6 misa", ctx, misa, m_misa());
    chk("R3 medeleg", ctx, medeleg, r_med);
    chk("R2 mideleg", ctx, mideleg, r_mid);
    chk("R2 mie", ctx, mie, r_mie);
    chk("R1 mip", ctx, mip, r_mip);
    chk("R7 mtvec", ctx, mtvec, r_mtvec);
    chk("R7 stvec", ctx, stvec, r_stvec);
    chk("R11 rdata", ctx, rdata, r_rdata);
    chk("R10 illegal", ctx, 64'(illegal), 64'(r_ill));
  endtask

  // called at a negedge; compares at the negedge after the capturing edge
  task automatic op(input bit w, input bit r, input logic [11:0] a, input logic [63:0] d, input string ctx);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    m_step(w, r, a, d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    compare_all(ctx);
  endtask

  task automatic wr_rd(input logic [11:0] a, input logic [63:0] d, input string ctx);
    op(1'b1, 1'b0, a, d, ctx);
    op(1'b0, 1'b1, a, 64'd0, ctx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [13] = '{12'h100, 12'h104, 12'h105, 12'h144, 12'h300, 12'h301,
                               12'h302, 12'h303, 12'h304, 12'h305, 12'h344, 12'h340, 12'h7C0};
    r_st = '0; r_mip = '0; r_mie = '0; r_mid = '0; r_med = '0;
    r_mtvec = '0; r_stvec = '0; r_rdata = '0; r_ext = '1; r_mpp = 2'd3; r_ill = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R12 reset");

    // all ones then all zeros on every owned register
    foreach (addrs[i]) wr_rd(addrs[i], '1, "R1 R2 R3 R6 R7 R8 ones");
    foreach (addrs[i]) wr_rd(addrs[i], '0, "R1 R2 R3 R6 R7 R8 zeros");

    // MPP legalization under three extension sets
    for (int v = 0; v < 4; v++) wr_rd(12'h300, 64'(v) << 11, "R4 full");
    max_isa = ISA_NO_S;
    for (int v = 0; v < 4; v++) wr_rd(12'h300, 64'(v) << 11, "R4 no S");
    max_isa = ISA_NO_U;
    for (int v = 0; v < 4; v++) wr_rd(12'h300, 64'(v) << 11, "R4 no U");
    max_isa = ISA_FULL;

    // SD derivation
    wr_rd(12'h300, 64'h6000, "R5 FS=3");
    wr_rd(12'h300, 64'h2000, "R5 FS=1");
    wr_rd(12'h300, 64'h18000, "R5 XS write");

    // misa coupling
    wr_rd(12'h301, 64'h0000_0008, "R6 F clear D set");
    wr_rd(12'h301, 64'h0000_0028, "R6 F and D set");
    wr_rd(12'h301, 64'h0000_0000, "R6 all clear");
    wr_rd(12'h301, 64'h03FF_FFFF, "R6 restore");

    // sstatus view
    wr_rd(12'h300, 64'h0, "R8 clear");
    wr_rd(12'h100, '1, "R8 ones");
    op(1'b0, 1'b1, 12'h300, 64'd0, "R8 mstatus after");

    // sip / sie through delegation
    wr_rd(12'h144, '1, "R9 none delegated");
    wr_rd(12'h303, 64'h0022, "R9 deleg set");
    wr_rd(12'h104, '1, "R9 sie ones");
    wr_rd(12'h144, '1, "R9 sip ones");
    op(1'b0, 1'b1, 12'h304, 64'd0, "R9 mie readback");
    wr_rd(12'h144, '0, "R9 sip zeros");

    // unowned addresses and read-during-write
    wr_rd(12'h340, '1, "R10 unowned");
    op(1'b0, 1'b1, 12'h7C0, 64'd0, "R10 back to back 1");
    op(1'b0, 1'b1, 12'h305, 64'd0, "R10 back to back 2");
    op(1'b0, 1'b0, 12'h305, 64'd0, "R10 R11 idle");
    op(1'b1, 1'b1, 12'h305, 64'h1234_5677, "R11 rw same cycle");
    op(1'b0, 1'b1, 12'h305, 64'd0, "R11 after write");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int k;
      k = $urandom_range(0, 12);
      if ($urandom_range(0, 15) == 0) begin
        case ($urandom_range(0, 2))
          0: max_isa = ISA_FULL;
          1: max_isa = ISA_NO_S;
          default: max_isa = ISA_NO_U;
        endcase
      end
      op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), addrs[k],
         {$urandom, $urandom}, "R1 R9 R10 R11 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule